// File: doc/BRIEF.md
# Clock Generator Configuration Slave (Write-Only Two-Wire)

This block is the configuration front end of a clock generator. It watches a two-wire serial bus (a clock line and a bidirectional data line) that is oversampled by the fast system clock. It picks out start and stop conditions and compares the first byte of each transaction with a fixed 7-bit device address. When that byte carries the device address and a write direction, the block acknowledges it and every data byte that follows. The data bytes fill a small bank of configuration registers.

The block takes no register-address byte. Every write transaction fills the bank from register 0 upward, one register per data byte. The bank drives a parallel image of all the bytes. It also drives decoded fields: a test-mode select, and enable bits for the CPU, PCI, SDRAM, USB/IO, IOAPIC and reference clock outputs. Most enable bits come out of reset set to 1 (clock running). The block only pulls the data line low. An external wired-AND pull-up gives the released level.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: The first byte after a start condition is compared bit by bit, most significant first, with the address 1101001 followed by a direction bit. Only when the address matches and the direction bit is 0 does the block acknowledge, by holding `sda_pull_low` high through the ninth clock pulse.
- R2: The data bytes of a transaction are stored in ascending registers, starting at register 0 in every transaction. The bits of each byte arrive most significant first. Register k appears on `cfg_image[8k+7:8k]`.
- R3: The decoded fields are taken from the register bytes as follows:
  - `test_mode` is register 0 bit 0.
  - `cpu_en[4:0]` is register 1 bits 4..0.
  - `usbio_en[0]` is register 1 bit 6 and `usbio_en[1]` is register 1 bit 7.
  - `pci_en[6:0]` is register 2 bits 6..0.
  - `sdram_en[7:0]` is register 3 and `sdram_en[15:8]` is register 4.
  - `ref_en[1:0]` is register 5 bits 1..0 and `apic_en[1:0]` is register 5 bits 5..4.
  - Register 6 is reserved storage.
  - An enable bit of 1 means the clock runs.
- R4: Each data byte of an acknowledged transaction is acknowledged in its ninth clock pulse. At every other time `sda_pull_low` is 0.
- R5: After an address byte that does not match, or that matches with direction bit 1, the block gives no acknowledge. It then stores nothing until the next start condition.
- R6: Data bytes that arrive after register 6 has been filled are still acknowledged, but they are discarded and change no register.
- R7: After reset the register bytes 0..6 hold 00, DF, 7F, FF, FF, 33 and 00 (hex). So `test_mode` is 0, every enable output is 1, and `sda_pull_low` is 0.
- R8: A register is updated only after all 8 of its bits have been received. A start or stop condition in the middle of a byte drops that byte and changes no register.
- R9: A repeated start ends the current transaction, and the next write again begins at register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the wire |
| sda_pull_low | output | 1 | 1 pulls the data line low (acknowledge) |
| cfg_image | output | NUM_REGS*8 | Parallel image of all registers, register k at bits 8k+7..8k |
| test_mode | output | 1 | Test-mode select |
| cpu_en | output | 5 | CPU clock enables |
| usbio_en | output | 2 | USB and IO clock enables |
| pci_en | output | 7 | PCI clock enables |
| sdram_en | output | 16 | SDRAM clock enables |
| ref_en | output | 2 | Reference clock enables |
| apic_en | output | 2 | IOAPIC clock enables |

## Verification
The hardest case to reach is a bus condition that arrives part way through a byte. The master must raise the data line while the clock is low and then create a stop or a repeated start with the clock high, after only some of the bits have gone out. The bench does this by sending a few loose bits after whole bytes, then issuing the condition directly. It then checks that the earlier whole bytes were kept and the partial byte was not. A second hard case is a transaction longer than the register bank. The bench sends twelve data bytes and checks that the five extra bytes are acknowledged but leave the image unchanged.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  localparam int unsigned CFG_BYTES = 7;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_ADDR,
    FR_ADDR_ACK,
    FR_DATA,
    FR_DATA_ACK,
    FR_SKIP
  } frame_st_t;

  // reset contents: enable bits on, reserved bits and test select off
  function automatic logic [7:0] cfg_reset_byte(input int unsigned idx);
    case (idx)
      1:       return 8'hDF;
      2:       return 8'h7F;
      3, 4:    return 8'hFF;
      5:       return 8'h33;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic b);
    return {cur[6:0], b};
  endfunction

  function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] dev);
    return (rx[7:1] == dev) && !rx[0];
  endfunction

endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/clkcfg_framer.sv
module clkcfg_framer
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'b1101001,
  parameter int unsigned NUM_REGS = CFG_BYTES,
  parameter int unsigned PTR_W    = $clog2(NUM_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  output logic             sda_pull,
  output logic             wr_strobe,
  output logic [PTR_W-1:0] wr_index,
  output logic [7:0]       wr_data,
  output logic [PTR_W-1:0] byte_ptr
);

  localparam logic [3:0] FULL_CNT = 4'd8;
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

  frame_st_t  st;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FR_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      sda_pull  <= 1'b0;
      wr_strobe <= 1'b0;
      wr_index  <= '0;
      wr_data   <= '0;
      byte_ptr  <= '0;
    end else begin
      wr_strobe <= 1'b0;
      if (start_ev) begin
        st       <= FR_ADDR;
        bit_cnt  <= '0;
        shreg    <= '0;
        byte_ptr <= '0;
        sda_pull <= 1'b0;
      end else if (stop_ev) begin
        st       <= FR_IDLE;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          FR_ADDR, FR_DATA: begin
            if (scl_rise && bit_cnt != FULL_CNT) begin
              shreg   <= shift_in(shreg, sda_s);
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == FULL_CNT) begin
              bit_cnt <= '0;
              if (st == FR_ADDR) begin
                if (addr_hit(shreg, DEV_ADDR)) begin
                  sda_pull <= 1'b1;
                  st       <= FR_ADDR_ACK;
                end else begin
                  st <= FR_SKIP;
                end
              end else begin
                sda_pull <= 1'b1;
                st       <= FR_DATA_ACK;
                if (byte_ptr < PTR_END) begin
                  wr_strobe <= 1'b1;
                  wr_index  <= byte_ptr;
                  wr_data   <= shreg;
                  byte_ptr  <= byte_ptr + 1'b1;
                end
              end
            end
          end
          FR_ADDR_ACK, FR_DATA_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              st       <= FR_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = CFG_BYTES,
  parameter int unsigned PTR_W    = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_strobe,
  input  logic [PTR_W-1:0]      wr_index,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] image
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST_VAL = cfg_reset_byte(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        image[8*g +: 8] <= RST_VAL;
      end else if (wr_strobe && wr_index == PTR_W'(g)) begin
        image[8*g +: 8] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'b1101001,
  parameter int unsigned NUM_REGS    = CFG_BYTES,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_pull_low,
  output logic [NUM_REGS*8-1:0] cfg_image,
  output logic                  test_mode,
  output logic [4:0]            cpu_en,
  output logic [1:0]            usbio_en,
  output logic [6:0]            pci_en,
  output logic [15:0]           sdram_en,
  output logic [1:0]            ref_en,
  output logic [1:0]            apic_en
);

  localparam int unsigned PTR_W = $clog2(NUM_REGS + 1);

  // named internal events, observed by the bound checker
  logic             scl_s;
  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             ev_start;
  logic             ev_stop;
  logic             wr_strobe;
  logic [PTR_W-1:0] wr_index;
  logic [7:0]       wr_data;
  logic [PTR_W-1:0] byte_ptr;

  clkcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (ev_start),
    .stop_ev  (ev_stop)
  );

  clkcfg_framer #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W)
  ) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (ev_start),
    .stop_ev   (ev_stop),
    .sda_pull  (sda_pull_low),
    .wr_strobe (wr_strobe),
    .wr_index  (wr_index),
    .wr_data   (wr_data),
    .byte_ptr  (byte_ptr)
  );

  clkcfg_regbank #(
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_strobe (wr_strobe),
    .wr_index  (wr_index),
    .wr_data   (wr_data),
    .image     (cfg_image)
  );

  assign test_mode = cfg_image[0];
  assign cpu_en    = cfg_image[8*1 +: 5];
  assign usbio_en  = cfg_image[8*1+6 +: 2];
  assign pci_en    = cfg_image[8*2 +: 7];
  assign sdram_en  = cfg_image[8*3 +: 16];
  assign ref_en    = cfg_image[8*5 +: 2];
  assign apic_en   = cfg_image[8*5+4 +: 2];

endmodule

// File: rtl/clkcfg_checker.sv
module clkcfg_checker #(
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned PTR_W    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  ev_start,
  input logic                  ev_stop,
  input logic                  sda_pull_low,
  input logic                  wr_strobe,
  input logic [PTR_W-1:0]      wr_index,
  input logic [PTR_W-1:0]      byte_ptr,
  input logic [NUM_REGS*8-1:0] cfg_image
);

  // R1: acknowledge is only applied while the clock line is low
  a_r1_ack_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> !scl_s);

  // R4: a stop condition always leaves the data line released
  a_r4_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_pull_low);

  // R9: a start condition rewinds the fill pointer to register 0
  a_r9_ptr_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (byte_ptr == '0));

  // R6: no write ever targets a register past the bank
  a_r6_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (int'(wr_index) < NUM_REGS));

  // R8: the image only changes through a completed byte write
  a_r8_image_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |=> $stable(cfg_image));

  // R8: a write is never issued while a bus condition is being seen
  a_r8_no_write_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start || ev_stop) |-> !wr_strobe);

endmodule

bind clkgen_cfg_slave clkcfg_checker #(
  .NUM_REGS (NUM_REGS),
  .PTR_W    (PTR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_s        (scl_s),
  .ev_start     (ev_start),
  .ev_stop      (ev_stop),
  .sda_pull_low (sda_pull_low),
  .wr_strobe    (wr_strobe),
  .wr_index     (wr_index),
  .byte_ptr     (byte_ptr),
  .cfg_image    (cfg_image)
);

// File: tb/test_clkgen_cfg_slave.sv
module test_clkgen_cfg_slave;

  localparam int Q = 10;
  localparam logic [6:0] MY_ADDR = 7'b1101001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_pull_low;
  logic [55:0] cfg_image;
  logic test_mode;
  logic [4:0] cpu_en;
  logic [1:0] usbio_en;
  logic [6:0] pci_en;
  logic [15:0] sdram_en;
  logic [1:0] ref_en;
  logic [1:0] apic_en;

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull_low;

  clkgen_cfg_slave i_clkgen_cfg_slave (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (m_scl),
    .sda_in       (sda_line),
    .sda_pull_low (sda_pull_low),
    .cfg_image    (cfg_image),
    .test_mode    (test_mode),
    .cpu_en       (cpu_en),
    .usbio_en     (usbio_en),
    .pci_en       (pci_en),
    .sdram_en     (sdram_en),
    .ref_en       (ref_en),
    .apic_en      (apic_en)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] model [7];
  logic [7:0] tx [12];
  logic [55:0] exp_q [$];
  string tag_q [$];
  event ev_check;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; m_sda = 1'b0; wq; m_scl = 1'b0; wq;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq; m_scl = 1'b1; wq; m_sda = 1'b1; wq;
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq; m_scl = 1'b1; wq; wq; m_scl = 1'b0; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wq; m_scl = 1'b1; wq;
    acked = ~sda_line;
    wq; m_scl = 1'b0; wq;
  endtask

  function automatic logic [55:0] pack_model();
    logic [55:0] v;
    for (int i = 0; i < 7; i++) v[8*i +: 8] = model[i];
    return v;
  endfunction

  task automatic push_expect(input string tag);
    exp_q.push_back(pack_model());
    tag_q.push_back(tag);
    repeat (20) @(negedge clk);
    -> ev_check;
    repeat (2) @(negedge clk);
  endtask

  // one complete transaction: address byte, n data bytes, stop
  task automatic txn(input logic [6:0] a, input logic rw, input int n, input string tag);
    logic ack;
    logic hit;
    int ptr;
    hit = (a == MY_ADDR) && !rw;
    ptr = 0;
    bus_start;
    send_byte({a, rw}, ack);
    chk({tag, " R1 address ack"}, 64'(ack), 64'(hit));
    for (int k = 0; k < n; k++) begin
      send_byte(tx[k], ack);
      chk({tag, " R4 data ack"}, 64'(ack), 64'(hit));
      if (hit && ptr < 7) begin
        model[ptr] = tx[k];
        ptr++;
      end
    end
    bus_stop;
    chk({tag, " R4 released after stop"}, 64'(sda_pull_low), 64'd0);
    push_expect(tag);
  endtask

  // monitor: pops each expected image and compares image and decoded fields
  initial begin
    logic [55:0] e;
    string t;
    forever begin
      @(ev_check);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " R2 image"}, 64'(cfg_image), 64'(e));
      chk({t, " R3 test_mode"}, 64'(test_mode), 64'(e[0]));
      chk({t, " R3 cpu_en"}, 64'(cpu_en), 64'(e[12:8]));
      chk({t, " R3 usbio_en"}, 64'(usbio_en), 64'(e[15:14]));
      chk({t, " R3 pci_en"}, 64'(pci_en), 64'(e[22:16]));
      chk({t, " R3 sdram_en"}, 64'(sdram_en), 64'(e[39:24]));
      chk({t, " R3 ref_en"}, 64'(ref_en), 64'(e[41:40]));
      chk({t, " R3 apic_en"}, 64'(apic_en), 64'(e[45:44]));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    model[0] = 8'h00; model[1] = 8'hDF; model[2] = 8'h7F; model[3] = 8'hFF;
    model[4] = 8'hFF; model[5] = 8'h33; model[6] = 8'h00;
    repeat (5) @(negedge clk);
    chk("R7 pull during reset", 64'(sda_pull_low), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 reset enables all on", 64'({cpu_en, usbio_en, pci_en, sdram_en, ref_en, apic_en}), 64'h3_FFFF_FFFF);
    push_expect("R7 reset");

    // full bank write
    tx[0] = 8'h01; tx[1] = 8'h5A; tx[2] = 8'h2C; tx[3] = 8'h96;
    tx[4] = 8'h3E; tx[5] = 8'h12; tx[6] = 8'hA5;
    txn(MY_ADDR, 1'b0, 7, "R2 full write");

    // short write starts again at register 0
    tx[0] = 8'h00; tx[1] = 8'hC3;
    txn(MY_ADDR, 1'b0, 2, "R2 short write");

    // wrong address: no ack, nothing stored
    tx[0] = 8'h01; tx[1] = 8'h00;
    txn(7'b1101000, 1'b0, 2, "R5 wrong address");

    // matching address with read direction
    txn(MY_ADDR, 1'b1, 2, "R5 read direction");

    // too many bytes: extras acked and dropped
    for (int k = 0; k < 12; k++) tx[k] = 8'(8'h30 + k * 8'h11);
    txn(MY_ADDR, 1'b0, 12, "R6 overlong write");

    // stop in the middle of the second data byte
    bus_start;
    send_byte({MY_ADDR, 1'b0}, ack);
    chk("R8 abort address ack", 64'(ack), 64'd1);
    send_byte(8'h01, ack);
    model[0] = 8'h01;
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    bus_stop;
    push_expect("R8 stop mid byte");

    // repeated start in the middle of a byte, new fill from register 0
    bus_start;
    send_byte({MY_ADDR, 1'b0}, ack);
    send_byte(8'h00, ack);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_start;
    send_byte({MY_ADDR, 1'b0}, ack);
    chk("R9 restart address ack", 64'(ack), 64'd1);
    send_byte(8'h01, ack);
    send_byte(8'h0F, ack);
    chk("R9 restart data ack", 64'(ack), 64'd1);
    model[0] = 8'h01;
    model[1] = 8'h0F;
    bus_stop;
    push_expect("R9 repeated start");

    // clear test mode, disable all PCI clocks
    tx[0] = 8'h00; tx[1] = 8'hDF; tx[2] = 8'h00;
    txn(MY_ADDR, 1'b0, 3, "R3 pci off");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule